// File: doc/BRIEF.md
# Port-C Edge Interrupt Controller

This block watches two lines (bit 0 and bit 4) of the third port in each of four I/O groups and turns selected transitions into latched interrupt requests. Every group owns one byte at a fixed register offset. A write to that byte sets the source mode and the trigger polarity. A read returns the same fields together with a pending flag. Software clears the flag by writing a 1 to it.

The source mode picks one of two sources: bit 0 alone, or bit 0 qualified by bit 4, which acts as a gate. Two mode codes turn the group off. The pending flags of all four groups, plus two pending flags from the neighbouring pattern-match and change-of-state logic, are ORed into one level-sensitive interrupt line. The port lines arrive already synchronized to the clock. Reads are combinational from the address, and writes take effect on the clock edge.

Top module: `pcei_top`

## Requirements
- R1: After a synchronous reset, every group byte reads 0x00 (mode off, falling polarity, no pending flag). With both companion flags low, `irq` is low.
- R2: Group n sits at address 16+n. A write stores bit 6 (polarity) and bits 5:4 (mode). Bits 3:0 always read as 0.
- R3: In mode 01, a transition on bit 0 of the group in the selected direction sets bit 7 (pending) on the clock edge where the new level is first sampled.
- R4: Bit 6 = 1 selects rising transitions and bit 6 = 0 selects falling transitions. A transition in the other direction does not set the flag.
- R5: In mode 10, a bit-0 transition of the selected direction sets the flag only when bit 4 of the same group is 1 in that cycle.
- R6: Modes 00 and 11 never set the flag, whatever the lines do.
- R7: Writing a byte with bit 7 = 1 clears the pending flag. Writing bit 7 = 0 leaves the flag as it was.
- R8: While the flag is set, further transitions are lost. After a clear, the flag stays 0 until a new transition arrives.
- R9: Writing the mode or polarity bits never sets the flag by itself, even when the line already sits at the newly selected level.
- R10: When a clearing write and a qualifying transition fall in the same cycle, the flag ends up set.
- R11: `irq` is high whenever any group flag or either companion flag is high. It stays high until every one of them is low.
- R12: Writes to addresses outside 16..19 change nothing, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte (combinational) |
| pc_bit0 | input | NG | Synchronized bit 0 of each group's port C |
| pc_bit4 | input | NG | Synchronized bit 4 of each group's port C (gate line) |
| pm_pend | input | 1 | Pending flag from the pattern-match logic |
| cos_pend | input | 1 | Pending flag from the change-of-state logic |
| irq | output | 1 | Combined level interrupt |

## Verification
The assertions assume that the port lines are already synchronous to `clk` and change at most once per cycle. They also assume that the companion flags are plain levels, so a transition is fully defined by comparing two successive samples. The bench changes lines, strobes and companion flags only on the falling clock edge and holds every write strobe for exactly one cycle. As a result, each pending flag is set or cleared by a single, known edge. The bench also starts with reset asserted, so every look into the past falls on defined values.

// File: rtl/pcei_pkg.sv
`timescale 1ns/1ps
package pcei_pkg;

    localparam int BYTE_W   = 8;
    localparam int FLAG_BIT = 7;
    localparam int POL_BIT  = 6;
    localparam int MODE_HI  = 5;
    localparam int MODE_LO  = 4;
    localparam int CTL_W    = BYTE_W - MODE_LO;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'b00,
        SRC_LINE  = 2'b01,
        SRC_GATED = 2'b10,
        SRC_OFF_B = 2'b11
    } src_mode_e;

    typedef struct packed {
        logic      pend;
        logic      rise;
        src_mode_e mode;
    } grp_cfg_t;

    function automatic logic [BYTE_W-1:0] status_byte(grp_cfg_t c);
        return {c.pend, c.rise, c.mode, {MODE_LO{1'b0}}};
    endfunction

    function automatic logic edge_seen(logic cur, logic prev, logic rise);
        return rise ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic logic src_fires(src_mode_e m, logic edge_ok, logic gate);
        case (m)
            SRC_LINE:  return edge_ok;
            SRC_GATED: return edge_ok & gate;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pcei_decode.sv
`timescale 1ns/1ps
module pcei_decode #(
    parameter int NG     = 4,
    parameter int ADDR_W = 6,
    parameter int BASE   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NG-1:0]     sel,
    output logic [NG-1:0]     wr_hit
);
    for (genvar g = 0; g < NG; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + g);
        assign sel[g]    = (addr == MY_ADDR);
        assign wr_hit[g] = wr & sel[g];
    end
endmodule

// File: rtl/pcei_group.sv
`timescale 1ns/1ps
module pcei_group
    import pcei_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] ctl,
    input  logic             src,
    input  logic             gate,
    output grp_cfg_t         cfg
);
    logic prev;
    logic fire;
    logic clr;

    assign fire = src_fires(cfg.mode, edge_seen(src, prev, cfg.rise), gate);
    assign clr  = wr & ctl[FLAG_BIT-MODE_LO];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= 1'b0;
            cfg.pend <= 1'b0;
            cfg.rise <= 1'b0;
            cfg.mode <= SRC_OFF;
        end else begin
            prev     <= src;
            cfg.pend <= fire | (cfg.pend & ~clr);
            if (wr) begin
                cfg.rise <= ctl[POL_BIT-MODE_LO];
                cfg.mode <= src_mode_e'(ctl[MODE_HI-MODE_LO:0]);
            end
        end
    end
endmodule

// File: rtl/pcei_top.sv
`timescale 1ns/1ps
module pcei_top
    import pcei_pkg::*;
#(
    parameter int NG     = 4,
    parameter int ADDR_W = 6,
    parameter int BASE   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NG-1:0]     pc_bit0,
    input  logic [NG-1:0]     pc_bit4,
    input  logic              pm_pend,
    input  logic              cos_pend,
    output logic              irq
);
    localparam int MODE_VW = 2 * NG;

    logic [NG-1:0]      sel;
    logic [NG-1:0]      wr_hit;
    logic [NG-1:0]      pend_vec;
    logic [MODE_VW-1:0] mode_vec;
    grp_cfg_t           cfg [NG];
    logic [BYTE_W-1:0]  status [NG];

    pcei_decode #(.NG(NG), .ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr   (reg_addr),
        .wr     (reg_wr),
        .sel    (sel),
        .wr_hit (wr_hit)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        pcei_group u_grp (
            .clk  (clk),
            .rst  (rst),
            .wr   (wr_hit[g]),
            .ctl  (reg_wdata[BYTE_W-1:MODE_LO]),
            .src  (pc_bit0[g]),
            .gate (pc_bit4[g]),
            .cfg  (cfg[g])
        );
        assign status[g]          = status_byte(cfg[g]);
        assign pend_vec[g]        = cfg[g].pend;
        assign mode_vec[2*g +: 2] = cfg[g].mode;
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NG; g++) begin
            if (sel[g]) reg_rdata = reg_rdata | status[g];
        end
    end

    assign irq = (|pend_vec) | pm_pend | cos_pend;

endmodule

// File: rtl/pcei_chk.sv
`timescale 1ns/1ps
module pcei_chk #(
    parameter int NG = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_wr,
    input logic [7:0]      reg_wdata,
    input logic [NG-1:0]   wr_hit,
    input logic [NG-1:0]   pc_bit0,
    input logic [NG-1:0]   pc_bit4,
    input logic [NG-1:0]   pend_vec,
    input logic [2*NG-1:0] mode_vec,
    input logic            pm_pend,
    input logic            cos_pend,
    input logic            irq
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1: reset leaves no pending flag
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (pend_vec == '0));

    // R11: irq falls only once every source is low
    p_irq_fall_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> (pend_vec == '0 && !pm_pend && !cos_pend));

    for (genvar g = 0; g < NG; g++) begin : g_prop
        // R6: a flag rises only under an enabled mode
        p_mode_gate_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_vec[g]) |->
                ($past(mode_vec[2*g +: 2]) == 2'b01 || $past(mode_vec[2*g +: 2]) == 2'b10));

        // R3: a flag rises only after bit 0 changed
        p_needs_edge_r3: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2 && $rose(pend_vec[g])) |->
                ($past(pc_bit0[g]) != $past(pc_bit0[g], 2)));

        // R5: gated mode needs bit 4 high
        p_gate_high_r5: assert property (@(posedge clk) disable iff (rst)
            ($rose(pend_vec[g]) && $past(mode_vec[2*g +: 2]) == 2'b10) |-> $past(pc_bit4[g]));

        // R7: a set flag holds unless a clearing write reached its group
        p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd1 && $past(pend_vec[g]) && !$past(wr_hit[g] && reg_wr && reg_wdata[7]))
                |-> pend_vec[g]);

        // R11: a new flag shows on irq
        p_irq_rise_r11: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_vec[g]) |-> irq);
    end
endmodule

bind pcei_top pcei_chk #(.NG(NG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .wr_hit    (wr_hit),
    .pc_bit0   (pc_bit0),
    .pc_bit4   (pc_bit4),
    .pend_vec  (pend_vec),
    .mode_vec  (mode_vec),
    .pm_pend   (pm_pend),
    .cos_pend  (cos_pend),
    .irq       (irq)
);

// File: tb/sim_pcei_top.sv
`timescale 1ns/1ps
module sim_pcei_top;
    localparam int NG = 4;
    localparam int AW = 6;
    localparam int NV = 26;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NG-1:0] pc_bit0 = '0;
    logic [NG-1:0] pc_bit4 = '0;
    logic          pm_pend = 1'b0;
    logic          cos_pend = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcei_top #(.NG(NG), .ADDR_W(AW), .BASE(16)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc_bit0(pc_bit0),
        .pc_bit4(pc_bit4), .pm_pend(pm_pend), .cos_pend(cos_pend), .irq(irq)
    );

    // fields: req, wr, waddr, wdata, bit0, bit4, raddr, exp_rd, exp_irq
    localparam logic [41:0] VEC [NV] = '{
        {4'd2,  1'b1, 6'd16, 8'h50, 4'b0000, 4'b0000, 6'd16, 8'h50, 1'b0}, // R2
        {4'd3,  1'b0, 6'd0,  8'h00, 4'b0001, 4'b0000, 6'd16, 8'hD0, 1'b1}, // R3
        {4'd7,  1'b1, 6'd16, 8'hD0, 4'b0001, 4'b0000, 6'd16, 8'h50, 1'b0}, // R7
        {4'd4,  1'b0, 6'd0,  8'h00, 4'b0000, 4'b0000, 6'd16, 8'h50, 1'b0}, // R4
        {4'd2,  1'b1, 6'd17, 8'h10, 4'b0000, 4'b0000, 6'd17, 8'h10, 1'b0}, // R2
        {4'd4,  1'b0, 6'd0,  8'h00, 4'b0010, 4'b0000, 6'd17, 8'h10, 1'b0}, // R4
        {4'd4,  1'b0, 6'd0,  8'h00, 4'b0000, 4'b0000, 6'd17, 8'h90, 1'b1}, // R4
        {4'd7,  1'b1, 6'd17, 8'h00, 4'b0000, 4'b0000, 6'd17, 8'h80, 1'b1}, // R7
        {4'd7,  1'b1, 6'd17, 8'h80, 4'b0000, 4'b0000, 6'd17, 8'h00, 1'b0}, // R7
        {4'd2,  1'b1, 6'd18, 8'h60, 4'b0000, 4'b0000, 6'd18, 8'h60, 1'b0}, // R2
        {4'd5,  1'b0, 6'd0,  8'h00, 4'b0100, 4'b0000, 6'd18, 8'h60, 1'b0}, // R5
        {4'd5,  1'b0, 6'd0,  8'h00, 4'b0000, 4'b0100, 6'd18, 8'h60, 1'b0}, // R5
        {4'd5,  1'b0, 6'd0,  8'h00, 4'b0100, 4'b0100, 6'd18, 8'hE0, 1'b1}, // R5
        {4'd7,  1'b1, 6'd18, 8'hE0, 4'b0100, 4'b0100, 6'd18, 8'h60, 1'b0}, // R7
        {4'd2,  1'b1, 6'd19, 8'h70, 4'b0100, 4'b0100, 6'd19, 8'h70, 1'b0}, // R2
        {4'd6,  1'b0, 6'd0,  8'h00, 4'b1100, 4'b0100, 6'd19, 8'h70, 1'b0}, // R6
        {4'd6,  1'b0, 6'd0,  8'h00, 4'b0100, 4'b0100, 6'd19, 8'h70, 1'b0}, // R6
        {4'd2,  1'b1, 6'd16, 8'h00, 4'b0100, 4'b0100, 6'd16, 8'h00, 1'b0}, // R2
        {4'd6,  1'b0, 6'd0,  8'h00, 4'b0101, 4'b0100, 6'd16, 8'h00, 1'b0}, // R6
        {4'd12, 1'b1, 6'd20, 8'hFF, 4'b0101, 4'b0100, 6'd20, 8'h00, 1'b0}, // R12
        {4'd12, 1'b1, 6'd15, 8'hFF, 4'b0101, 4'b0100, 6'd16, 8'h00, 1'b0}, // R12
        {4'd9,  1'b0, 6'd0,  8'h00, 4'b0111, 4'b0100, 6'd17, 8'h00, 1'b0}, // R9
        {4'd9,  1'b1, 6'd17, 8'h50, 4'b0111, 4'b0100, 6'd17, 8'h50, 1'b0}, // R9
        {4'd9,  1'b1, 6'd17, 8'h10, 4'b0111, 4'b0100, 6'd17, 8'h10, 1'b0}, // R9
        {4'd4,  1'b0, 6'd0,  8'h00, 4'b0101, 4'b0100, 6'd17, 8'h90, 1'b1}, // R4
        {4'd7,  1'b1, 6'd17, 8'h90, 4'b0101, 4'b0100, 6'd17, 8'h10, 1'b0}  // R7
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    // entered on a falling edge; one clock later reads back raddr
    task automatic step(input int req, input logic wr, input logic [AW-1:0] waddr,
                        input logic [7:0] wdata, input logic [NG-1:0] b0,
                        input logic [NG-1:0] b4, input logic [AW-1:0] raddr,
                        input logic [7:0] exp_rd, input logic exp_irq);
        reg_wr    = wr;
        reg_addr  = waddr;
        reg_wdata = wdata;
        pc_bit0   = b0;
        pc_bit4   = b4;
        @(posedge clk);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = raddr;
        #1;
        check(req, reg_rdata, exp_rd);
        check(req, {7'd0, irq}, {7'd0, exp_irq});
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of every group byte and irq
        for (int g = 0; g < NG; g++) begin
            reg_addr = AW'(16 + g);
            #1;
            check(1, reg_rdata, 8'h00);
        end
        check(1, {7'd0, irq}, 8'h00);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            step(int'(v[41:38]), v[37], v[36:31], v[30:23], v[22:19], v[18:15],
                 v[14:9], v[8:1], v[0]);
        end

        // R8: transitions while pending are lost
        step(2, 1'b1, 6'd16, 8'h50, 4'b0100, 4'b0100, 6'd16, 8'h50, 1'b0);
        step(8, 1'b0, 6'd0,  8'h00, 4'b0101, 4'b0100, 6'd16, 8'hD0, 1'b1);
        step(8, 1'b0, 6'd0,  8'h00, 4'b0100, 4'b0100, 6'd16, 8'hD0, 1'b1);
        step(8, 1'b0, 6'd0,  8'h00, 4'b0101, 4'b0100, 6'd16, 8'hD0, 1'b1);
        step(8, 1'b1, 6'd16, 8'hD0, 4'b0101, 4'b0100, 6'd16, 8'h50, 1'b0);
        step(8, 1'b0, 6'd0,  8'h00, 4'b0101, 4'b0100, 6'd16, 8'h50, 1'b0);

        // R10: clear and transition in the same cycle
        step(10, 1'b0, 6'd0,  8'h00, 4'b0100, 4'b0100, 6'd16, 8'h50, 1'b0);
        step(10, 1'b0, 6'd0,  8'h00, 4'b0101, 4'b0100, 6'd16, 8'hD0, 1'b1);
        step(10, 1'b0, 6'd0,  8'h00, 4'b0100, 4'b0100, 6'd16, 8'hD0, 1'b1);
        step(10, 1'b1, 6'd16, 8'hD0, 4'b0101, 4'b0100, 6'd16, 8'hD0, 1'b1);
        step(10, 1'b1, 6'd16, 8'hD0, 4'b0101, 4'b0100, 6'd16, 8'h50, 1'b0);

        // R11: irq stays high until the last flag clears
        step(11, 1'b0, 6'd0,  8'h00, 4'b0000, 4'b0100, 6'd18, 8'h60, 1'b0);
        step(11, 1'b0, 6'd0,  8'h00, 4'b0101, 4'b0100, 6'd18, 8'hE0, 1'b1);
        step(11, 1'b1, 6'd16, 8'hD0, 4'b0101, 4'b0100, 6'd16, 8'h50, 1'b1);
        step(11, 1'b1, 6'd18, 8'hE0, 4'b0101, 4'b0100, 6'd18, 8'h60, 1'b0);

        // R11: companion flags reach irq
        pm_pend = 1'b1;
        #1;
        check(11, {7'd0, irq}, 8'h01);
        pm_pend  = 1'b0;
        cos_pend = 1'b1;
        #1;
        check(11, {7'd0, irq}, 8'h01);
        cos_pend = 1'b0;
        #1;
        check(11, {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule